// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Controller

This block lets an array of DRAM-style cells, which lose their contents unless each row is touched often enough, be used as if it were a static RAM. The host sees a plain non-multiplexed port: a select, a write strobe, an output-enable pin that also serves as a refresh pulse input, a flat address and a byte of write data. The upper address bits pick a row and the lower bits pick a byte within that row. Any read or write also counts as a refresh of the row it touches.

Three refresh sources share one row tracker and keep every row inside its retention window. In the first, the host selects a row without reading or writing it. In the second, the host pulses the output-enable/refresh pin while the port is deselected, and an internal wrapping row counter supplies the row. In the third, an idle timer notices that the host has gone quiet and then walks the same counter by itself. A self-refresh row operation briefly holds the port not-ready. The host request is a valid/ready pair (`host_sel` / `host_ready`): the host holds its request and its fields steady until a clock edge where ready is high, and that edge accepts it. Read data comes back on the next cycle with `rd_valid`, and the read return path has no back-pressure. A per-row age tracker raises a sticky error if any row outlives the window.

The default parameters give a small array for elaboration. A full 32K×8 part with 256 rows is `ROW_BITS=8`, `COL_BITS=7`.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: A write accepted at address A followed by an accepted read of A returns the written byte on `rd_data`, with `rd_valid` high in exactly the cycle after the read is accepted. A request is decoded as a write when `host_we`=1, and as a read when `host_we`=0 and `host_oe_rf`=1.
- R2: An accepted request with `host_we`=0 and `host_oe_rf`=0 is a row-only refresh. It does not raise `rd_valid` and leaves every stored byte unchanged.
- R3: Each row has an age count of clock cycles. If any row goes more than `WINDOW` cycles without a refresh or access, `retention_err` goes high and stays high until reset.
- R4: A rising edge on `host_oe_rf` while `host_sel` is low refreshes the row named by an internal counter, and the counter then advances, wrapping from the last row to row 0. Pulses spaced at most `WINDOW/ROWS` cycles apart keep `retention_err` low with no host addresses. Each pulse counts as activity, so self refresh does not start.
- R5: After `IDLE_LIMIT` consecutive cycles with no host activity, the first self-refresh operation starts on the next cycle. Further operations follow every `SR_GAP = WINDOW/(2·ROWS)` cycles. Each one holds `host_ready` low for exactly `OP_CYC` cycles, and this alone keeps `retention_err` low.
- R6: A request made while `host_ready` is low is held and then accepted at the first ready edge. Its wait is at most `OP_CYC` cycles. After any accepted request the idle timer restarts, so the next self-refresh operation begins `IDLE_LIMIT+1` cycles after acceptance.
- R7: No refresh of any kind, including long stretches of self refresh, changes stored data.
- R8: After reset, `host_ready`=1, `rd_valid`=0 and `retention_err`=0.
- R9: Ordinary writes that visit every row within the window keep `retention_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Request valid (chip select) |
| host_we | input | 1 | Write strobe for the request |
| host_oe_rf | input | 1 | Output enable while selected; refresh pulse while deselected |
| host_addr | input | ROW_BITS+COL_BITS | Byte address, row in the upper bits |
| host_wdata | input | DW | Write data |
| host_ready | output | 1 | Request ready; low during a self-refresh row operation |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| retention_err | output | 1 | Sticky flag: some row exceeded its retention window |

## Verification
The bench runs each refresh method on its own from a fresh reset and checks that the retention flag stays low. A counter that fails to advance or wrap, or a self-refresh spacing that is too wide, would let a row age out and raise the flag. The bench hammers a single row so that the flag must rise just after the window, and then checks that it survives a quiet period; an off-by-one window or a flag that is not sticky shows up there. It times the first self-refresh operation against the idle limit, both after reset and after a stalled host read, and measures every not-ready stretch. A design that failed to restart its idle timer, or that held the port for the wrong length, would miss these counts. Reads after long self-refresh runs would expose any refresh that disturbed data.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    HOP_IDLE   = 2'd0,
    HOP_WRITE  = 2'd1,
    HOP_READ   = 2'd2,
    HOP_ROWREF = 2'd3
  } host_op_e;

  // Classify an accepted host request from the port strobes.
  function automatic host_op_e decode_op(input logic go, input logic we, input logic oe);
    if (!go)     return HOP_IDLE;
    else if (we) return HOP_WRITE;
    else if (oe) return HOP_READ;
    else         return HOP_ROWREF;
  endfunction

endpackage

// File: rtl/psr_cell_array.sv
module psr_cell_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // Behavioural storage: refresh never reaches this array, only writes do.
  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
    if (rd_en) rdata <= cells[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_en;
  end
endmodule

// File: rtl/psr_row_tracker.sv
module psr_row_tracker #(
  parameter int RW     = 8,
  parameter int WINDOW = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic [RW-1:0] a_row,
  input  logic          b_en,
  input  logic [RW-1:0] b_row,
  output logic          expired
);
  localparam int             ROWS  = 1 << RW;
  localparam int             AGW   = $clog2(WINDOW + 1);
  localparam logic [AGW-1:0] LIMIT = AGW'(WINDOW);

  logic [ROWS-1:0] late;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGW-1:0] age_q;
    logic           hit;

    assign hit = (a_en && a_row == RW'(r)) || (b_en && b_row == RW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= '0;
      else if (hit)            age_q <= '0;
      else if (age_q != LIMIT) age_q <= age_q + AGW'(1);
    end

    // The row has already waited WINDOW cycles and is missed again.
    assign late[r] = (age_q == LIMIT) && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     expired <= 1'b0;
    else if (|late) expired <= 1'b1;
  end
endmodule

// File: rtl/psr_refresh_sched.sv
module psr_refresh_sched #(
  parameter int RW         = 8,
  parameter int IDLE_LIMIT = 64,
  parameter int SR_GAP     = 390,
  parameter int OP_CYC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          oe_rf,
  output logic          ready,
  output logic          ref_en,
  output logic [RW-1:0] ref_row
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam int GW = $clog2(SR_GAP + 1);
  localparam int BW = $clog2(OP_CYC + 1);

  logic          oe_q, pend_q;
  logic [IW-1:0] idle_q;
  logic [GW-1:0] gap_q;
  logic [BW-1:0] busy_q;
  logic [RW-1:0] row_q;

  logic busy, oe_edge, activity, sr_mode, auto_fire, sr_fire;

  assign busy      = (busy_q != '0);
  assign oe_edge   = oe_rf && !oe_q && !host_sel;
  assign activity  = host_sel || oe_edge || pend_q;
  assign sr_mode   = (idle_q == IW'(IDLE_LIMIT));
  assign auto_fire = (oe_edge || pend_q) && !busy;
  assign sr_fire   = sr_mode && !activity && !busy && (gap_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
      idle_q <= '0;
      gap_q  <= '0;
      busy_q <= '0;
      row_q  <= '0;
    end else begin
      oe_q <= oe_rf;

      // A pulse that lands on a self-refresh operation is served afterwards.
      if (oe_edge && busy) pend_q <= 1'b1;
      else if (auto_fire)  pend_q <= 1'b0;

      if (activity)     idle_q <= '0;
      else if (!sr_mode) idle_q <= idle_q + IW'(1);

      if (activity)            gap_q <= '0;
      else if (sr_fire)        gap_q <= GW'(SR_GAP - 1);
      else if (gap_q != '0)    gap_q <= gap_q - GW'(1);

      if (sr_fire)   busy_q <= BW'(OP_CYC);
      else if (busy) busy_q <= busy_q - BW'(1);

      // Shared counter: wraps naturally at the power-of-two row count.
      if (auto_fire || sr_fire) row_q <= row_q + RW'(1);
    end
  end

  assign ready   = !busy;
  assign ref_en  = auto_fire || sr_fire;
  assign ref_row = row_q;
endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
  import psr_pkg::*;
#(
  parameter int ROW_BITS   = 8,
  parameter int COL_BITS   = 3,
  parameter int DW         = 8,
  parameter int WINDOW     = 200000,
  parameter int IDLE_LIMIT = 64,
  parameter int OP_CYC     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_sel,
  input  logic                         host_we,
  input  logic                         host_oe_rf,
  input  logic [ROW_BITS+COL_BITS-1:0] host_addr,
  input  logic [DW-1:0]                host_wdata,
  output logic                         host_ready,
  output logic [DW-1:0]                rd_data,
  output logic                         rd_valid,
  output logic                         retention_err
);
  localparam int AW     = ROW_BITS + COL_BITS;
  localparam int ROWS   = 1 << ROW_BITS;
  localparam int SR_GAP = WINDOW / (2 * ROWS);

  host_op_e            op;
  logic                go;
  logic                sched_ref;
  logic [ROW_BITS-1:0] sched_row, host_row;

  assign go       = host_sel && host_ready;
  assign op       = decode_op(go, host_we, host_oe_rf);
  assign host_row = host_addr[AW-1 -: ROW_BITS];

  psr_refresh_sched #(
    .RW(ROW_BITS), .IDLE_LIMIT(IDLE_LIMIT), .SR_GAP(SR_GAP), .OP_CYC(OP_CYC)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .oe_rf(host_oe_rf),
    .ready(host_ready), .ref_en(sched_ref), .ref_row(sched_row)
  );

  psr_row_tracker #(.RW(ROW_BITS), .WINDOW(WINDOW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .a_en(op != HOP_IDLE), .a_row(host_row),
    .b_en(sched_ref), .b_row(sched_row),
    .expired(retention_err)
  );

  psr_cell_array #(.AW(AW), .DW(DW)) u_cells (
    .clk(clk), .rst_n(rst_n),
    .wr_en(op == HOP_WRITE), .rd_en(op == HOP_READ),
    .addr(host_addr), .wdata(host_wdata),
    .rdata(rd_data), .rvalid(rd_valid)
  );
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int OP_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic host_sel,
  input logic host_we,
  input logic host_oe_rf,
  input logic host_ready,
  input logic rd_valid,
  input logic retention_err
);
  logic       armed;
  logic [7:0] low_run;
  logic       rd_go;

  assign rd_go = host_sel && host_ready && !host_we && host_oe_rf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_run <= '0;
    end else begin
      armed <= 1'b1;
      if (host_ready)          low_run <= '0;
      else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
    end
  end

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_go) |=> rd_valid); // R1
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rd_go) |=> !rd_valid); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && retention_err) |=> retention_err); // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    int'(low_run) <= OP_CYC); // R5
  AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && host_sel && host_ready) |=> host_ready); // R6
endmodule

bind psram_refresh_ctrl psr_checker #(.OP_CYC(OP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
  .host_oe_rf(host_oe_rf), .host_ready(host_ready), .rd_valid(rd_valid),
  .retention_err(retention_err)
);

// File: tb/sim_psram_refresh_ctrl.sv
module sim_psram_refresh_ctrl;
  localparam int RB = 4, CB = 2, AW = RB + CB, DW = 8;
  localparam int WIN = 400, IDLE = 40, OPC = 2;
  localparam int ROWS = 1 << RB;
  localparam int GAP = WIN / (2 * ROWS);

  // {op[1:0], addr[5:0], data[7:0]}; op 0 write, 1 read, 2 row-only refresh
  localparam logic [15:0] VEC [16] = '{
    16'h00A5, 16'h3F5A, 16'h15C3, 16'h4000, 16'h7F00, 16'h8000, 16'h4000, 16'h1511,
    16'h5500, 16'h20FF, 16'hA000, 16'h6000, 16'h7F00, 16'h0100, 16'h4100, 16'h5500
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rvalid, err;
  logic [DW-1:0] rdata;

  int errs = 0, checks = 0;
  logic [7:0] shadow [64];
  logic [7:0] rd;
  logic rv;
  int st;

  always #10 clk = ~clk;

  psram_refresh_ctrl #(
    .ROW_BITS(RB), .COL_BITS(CB), .DW(DW), .WINDOW(WIN), .IDLE_LIMIT(IDLE), .OP_CYC(OPC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_we(we), .host_oe_rf(oe),
    .host_addr(addr), .host_wdata(wdata), .host_ready(ready),
    .rd_data(rdata), .rd_valid(rvalid), .retention_err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; oe = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic access(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        output logic [7:0] r, output logic v, output int stalls);
    addr = a; wdata = d; sel = 1'b1; we = (op == 2'd0); oe = (op == 2'd1);
    stalls = 0;
    while (!ready) begin step(); stalls++; end
    step();
    sel = 1'b0; we = 1'b0; oe = 1'b0;
    r = rdata; v = rvalid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    // R8: reset state
    check(ready == 1'b1, "R8", "ready after reset", int'(ready), 1);
    check(rvalid == 1'b0, "R8", "rd_valid after reset", int'(rvalid), 0);
    check(err == 1'b0, "R8", "retention_err after reset", int'(err), 0);

    // R1 / R2: vector table
    for (int i = 0; i < 16; i++) begin
      logic [1:0] op;
      logic [5:0] a;
      logic [7:0] d;
      op = VEC[i][15:14]; a = VEC[i][13:8]; d = VEC[i][7:0];
      access(op, a, d, rd, rv, st);
      if (op == 2'd0) shadow[a] = d;
      else if (op == 2'd1) begin
        check(rv == 1'b1, "R1", "rd_valid after read", int'(rv), 1);
        check(rd == shadow[a], "R1", "read data", int'(rd), int'(shadow[a]));
      end else begin
        check(rv == 1'b0, "R2", "rd_valid after row refresh", int'(rv), 0);
      end
    end

    // R3: only row 0 refreshed, flag must rise just past the window and stick
    do_reset();
    addr = '0; sel = 1'b1; we = 1'b0; oe = 1'b0;
    repeat (WIN - 5) step();
    check(err == 1'b0, "R3", "flag before window", int'(err), 0);
    repeat (10) step();
    check(err == 1'b1, "R3", "flag after window", int'(err), 1);
    sel = 1'b0;
    repeat (60) step();
    check(err == 1'b1, "R3", "flag sticky", int'(err), 1);
    do_reset();
    check(err == 1'b0, "R8", "flag cleared by reset", int'(err), 0);
    check(ready == 1'b1, "R8", "ready after second reset", int'(ready), 1);

    // R9: ordinary writes sweeping all rows
    for (int s = 0; s < 60; s++)
      for (int r = 0; r < ROWS; r++)
        access(2'd0, {r[RB-1:0], 2'b00}, 8'(r ^ s), rd, rv, st);
    check(err == 1'b0, "R9", "flag with write sweeps", int'(err), 0);
    for (int r = 0; r < ROWS; r += 5) begin
      access(2'd1, {r[RB-1:0], 2'b00}, 8'h00, rd, rv, st);
      check(rd == 8'(r ^ 59), "R9", "sweep data", int'(rd), int'(8'(r ^ 59)));
    end

    // R4: pulse-driven refresh with internal counter, several wraps
    do_reset();
    begin
      int lows;
      lows = 0;
      repeat (60) begin
        oe = 1'b1; step(); if (!ready) lows++;
        oe = 1'b0;
        repeat (19) begin step(); if (!ready) lows++; end
      end
      check(err == 1'b0, "R4", "flag with pulse refresh", int'(err), 0);
      check(lows == 0, "R4", "no self refresh during pulses", lows, 0);
    end

    // R5: autonomous self refresh
    do_reset();
    begin
      int first_low, runs, bad, cur, exp_runs;
      first_low = 0; runs = 0; bad = 0; cur = 0;
      for (int n = 1; n <= 3 * WIN; n++) begin
        step();
        if (!ready) begin
          if (first_low == 0) first_low = n;
          cur++;
        end else if (cur > 0) begin
          if (cur != OPC) bad++;
          runs++; cur = 0;
        end
      end
      exp_runs = (3 * WIN - (IDLE + 1)) / GAP + 1;
      check(first_low == IDLE + 1, "R5", "first self-refresh cycle", first_low, IDLE + 1);
      check(bad == 0, "R5", "not-ready stretches of wrong length", bad, 0);
      check(runs == exp_runs, "R5", "self-refresh operation count", runs, exp_runs);
      check(err == 1'b0, "R5", "flag under self refresh", int'(err), 0);
    end

    // R6 / R7: stalled read during a self-refresh operation
    do_reset();
    access(2'd0, 6'h2A, 8'h6C, rd, rv, st);
    repeat (WIN) step();
    while (!ready) step();
    while (ready) step();
    access(2'd1, 6'h2A, 8'h00, rd, rv, st);
    check(st == OPC, "R6", "stall cycles", st, OPC);
    check(rv == 1'b1, "R6", "stalled read valid", int'(rv), 1);
    check(rd == 8'h6C, "R7", "data after self refresh", int'(rd), 8'h6C);
    begin
      int n;
      n = 0;
      do begin step(); n++; end while (ready && n < 200);
      check(n == IDLE + 1, "R6", "idle timer restart", n, IDLE + 1);
    end

    // R7: early data survived every refresh phase
    access(2'd1, 6'h15, 8'h00, rd, rv, st);
    check(rd == 8'h11, "R7", "data at 0x15", int'(rd), 8'h11);
    access(2'd1, 6'h3F, 8'h00, rd, rv, st);
    check(rd == 8'h5A, "R7", "data at 0x3F", int'(rd), 8'h5A);
    check(err == 1'b0, "R5", "flag at end", int'(err), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule